// File: doc/BRIEF.md
# Multicast Fat-Tree Distribution Network

This block carries operands (weights or input activations) from a buffer-side root to a row of `NUM_LEAVES` leaf compute units. Every packet arrives with a data word and a destination bitmask with one bit per leaf. A single traversal delivers the word to every leaf named in the mask, so one buffer read can feed many multipliers at once.

Links widen toward the root, as in a fat tree. The root has `ROOT_BW` injection ports, and several packets can enter in the same cycle as long as their paths fit the link capacity of every node they pass. A node at level `l` (root = 0) passes at most `max(1, ROOT_BW >> l)` packets per cycle. The root decides which ports enter in a cycle and uses valid/ready handshakes to hold back the packets that do not fit. Accepted packets move through one register per tree level and appear at the leaves as single-cycle valid pulses.

Top module: `mcast_fat_tree`

## Requirements
- R1: A packet accepted on port p is delivered with its data word to exactly the leaves whose bits are set in its mask, once each. No other leaf sees it. Leaf k corresponds to mask bit k, and port p uses mask slice `[p*NUM_LEAVES +: NUM_LEAVES]` and data slice `[p*DW +: DW]`.
- R2: The leaf pulse for a packet accepted at clock edge k is visible during the cycle after edge k+DEPTH-1, where DEPTH = log2(NUM_LEAVES). A leaf that receives nothing has `leaf_valid` low.
- R3: The tree is a heap. Node 1 is the root, the children of node i are 2i and 2i+1, and leaf k is node NUM_LEAVES+k. A node is used by a packet when any mask bit in its subtree is set. A node at level l carries at most max(1, ROOT_BW >> l) accepted packets per cycle.
- R4: Ports are examined in increasing index order. A port's `in_ready` is high exactly when its node footprint fits within the capacity left by the lower-indexed ports that are valid and ready. A port that is not valid, or is refused, uses no capacity. Port 0 is always ready.
- R5: A packet whose mask is all zeros is always accepted, uses no capacity and produces no leaf pulse.
- R6: While reset is asserted, and until a packet completes its traversal after reset, every `leaf_valid` bit is low.
- R7: A new set of packets can be accepted every cycle. Nothing internal stalls the pipeline.
- R8: Two packets accepted in the same cycle never share a leaf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | ROOT_BW | Packet present on each root port |
| in_ready | output | ROOT_BW | Port's packet fits this cycle |
| in_mask | input | ROOT_BW*NUM_LEAVES | Destination leaf mask per port |
| in_data | input | ROOT_BW*DW | Data word per port |
| leaf_valid | output | NUM_LEAVES | Delivery pulse per leaf |
| leaf_data | output | NUM_LEAVES*DW | Delivered word per leaf |

## Verification
The assertions assume that a producer presents only packets it means to inject and that `in_mask` and `in_valid` are stable between clock edges. The pairwise-disjoint check also relies on `NUM_LEAVES` being a power of two that is at least `ROOT_BW`. The stimulus changes inputs only on falling edges and keeps the default power-of-two sizes. It mixes single-leaf, sparse, quarter-block, broadcast and empty masks, so every capacity level is stressed. Refused packets are simply redrawn on the next cycle. This is legal because the block places no ordering demand on the producer.

// File: rtl/mcast_fat_tree.sv
module mcast_fat_tree #(
  parameter int NUM_LEAVES = 16,
  parameter int ROOT_BW    = 4,
  parameter int DW         = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ROOT_BW-1:0]               in_valid,
  output logic [ROOT_BW-1:0]               in_ready,
  input  logic [ROOT_BW*NUM_LEAVES-1:0]    in_mask,
  input  logic [ROOT_BW*DW-1:0]            in_data,
  output logic [NUM_LEAVES-1:0]            leaf_valid,
  output logic [NUM_LEAVES*DW-1:0]         leaf_data
);
  localparam int DEPTH = $clog2(NUM_LEAVES);
  localparam int NODES = 2 * NUM_LEAVES;
  localparam int CW    = $clog2(ROOT_BW + 1);

  logic [CW-1:0]    cap [NODES];
  logic [NODES-1:0] hit [ROOT_BW];

  assign cap[0] = '0;
  for (genvar i = 1; i < NODES; i++) begin : g_cap
    localparam int LVL = $clog2(i + 1) - 1;
    localparam int RAW = ROOT_BW >> LVL;
    assign cap[i] = CW'((RAW < 1) ? 1 : RAW);
  end

  for (genvar p = 0; p < ROOT_BW; p++) begin : g_hit
    assign hit[p][0] = 1'b0;
    assign hit[p][NODES-1:NUM_LEAVES] = in_mask[p*NUM_LEAVES +: NUM_LEAVES];
    for (genvar i = 1; i < NUM_LEAVES; i++) begin : g_up
      assign hit[p][i] = hit[p][2*i] | hit[p][2*i+1];
    end
  end

  always_comb begin
    logic [CW-1:0] used [NODES];
    logic          ok;
    for (int i = 0; i < NODES; i++) used[i] = '0;
    in_ready = '0;
    for (int p = 0; p < ROOT_BW; p++) begin
      ok = 1'b1;
      for (int i = 1; i < NODES; i++)
        if (hit[p][i] && used[i] >= cap[i]) ok = 1'b0;
      in_ready[p] = ok;
      if (ok && in_valid[p])
        for (int i = 1; i < NODES; i++)
          if (hit[p][i]) used[i] = used[i] + 1'b1;
    end
  end

  logic [ROOT_BW-1:0]    st_v [DEPTH];
  logic [NUM_LEAVES-1:0] st_m [DEPTH][ROOT_BW];
  logic [DW-1:0]         st_d [DEPTH][ROOT_BW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) st_v[d] <= '0;
    end else begin
      st_v[0] <= in_valid & in_ready;
      for (int d = 1; d < DEPTH; d++) st_v[d] <= st_v[d-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < ROOT_BW; p++) begin
      st_m[0][p] <= in_mask[p*NUM_LEAVES +: NUM_LEAVES];
      st_d[0][p] <= in_data[p*DW +: DW];
    end
    for (int d = 1; d < DEPTH; d++) begin
      st_m[d] <= st_m[d-1];
      st_d[d] <= st_d[d-1];
    end
  end

  always_comb begin
    leaf_valid = '0;
    leaf_data  = '0;
    for (int p = 0; p < ROOT_BW; p++)
      if (st_v[DEPTH-1][p]) begin
        leaf_valid = leaf_valid | st_m[DEPTH-1][p];
        for (int k = 0; k < NUM_LEAVES; k++)
          if (st_m[DEPTH-1][p][k])
            leaf_data[k*DW +: DW] = leaf_data[k*DW +: DW] | st_d[DEPTH-1][p];
      end
  end
endmodule

// File: rtl/mcast_fat_tree_chk.sv
module mcast_fat_tree_chk #(
  parameter int NUM_LEAVES = 16,
  parameter int ROOT_BW    = 4,
  parameter int DW         = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ROOT_BW-1:0]            in_valid,
  input logic [ROOT_BW-1:0]            in_ready,
  input logic [ROOT_BW*NUM_LEAVES-1:0] in_mask,
  input logic [NUM_LEAVES-1:0]         leaf_valid
);
  localparam int DEPTH = $clog2(NUM_LEAVES);

  logic [DEPTH:0] hist;
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[DEPTH-1:0], |(in_valid & in_ready)};
  end

  // R2 / R6: a leaf pulse needs an acceptance exactly DEPTH edges earlier
  a_r2_pulse_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|leaf_valid) |-> hist[DEPTH-1]);

  a_r4_port0_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready[0]);

  for (genvar p = 0; p < ROOT_BW; p++) begin : g_p
    a_r5_empty_mask_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mask[p*NUM_LEAVES +: NUM_LEAVES] == '0) |-> in_ready[p]);
    for (genvar q = p + 1; q < ROOT_BW; q++) begin : g_q
      a_r8_disjoint_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[p] && in_ready[p] && in_valid[q] && in_ready[q]) |->
        ((in_mask[p*NUM_LEAVES +: NUM_LEAVES] & in_mask[q*NUM_LEAVES +: NUM_LEAVES]) == '0));
    end
  end
endmodule

bind mcast_fat_tree mcast_fat_tree_chk #(
  .NUM_LEAVES(NUM_LEAVES), .ROOT_BW(ROOT_BW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .leaf_valid(leaf_valid)
);

// File: tb/tb_mcast_fat_tree.sv
`timescale 1ns/1ps
module tb_mcast_fat_tree;
  localparam int N  = 16;
  localparam int B  = 4;
  localparam int DW = 8;
  localparam int D  = $clog2(N);
  localparam int RING = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [B-1:0]    vld = '0;
  logic [B-1:0]    rdy;
  logic [B*N-1:0]  msk = '0;
  logic [B*DW-1:0] dat = '0;
  logic [N-1:0]    lv;
  logic [N*DW-1:0] ld;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0]    exp_v [RING];
  logic [N*DW-1:0] exp_d [RING];

  always #5 clk = ~clk;

  mcast_fat_tree #(.NUM_LEAVES(N), .ROOT_BW(B), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(rdy),
    .in_mask(msk), .in_data(dat), .leaf_valid(lv), .leaf_data(ld));

  function automatic int node_cap(int i);
    int lvl = 0;
    int c;
    for (int x = i; x > 1; x = x / 2) lvl++;
    c = B >> lvl;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [B-1:0] model_ready(logic [B-1:0] v, logic [B*N-1:0] m);
    int used [2*N];
    logic [2*N-1:0] h;
    logic [B-1:0] r;
    logic ok;
    for (int i = 0; i < 2*N; i++) used[i] = 0;
    r = '0;
    for (int p = 0; p < B; p++) begin
      h = '0;
      for (int k = 0; k < N; k++) h[N+k] = m[p*N+k];
      for (int i = N-1; i >= 1; i--) h[i] = h[2*i] | h[2*i+1];
      ok = 1'b1;
      for (int i = 1; i < 2*N; i++) if (h[i] && used[i] >= node_cap(i)) ok = 1'b0;
      r[p] = ok;
      if (ok && v[p]) for (int i = 1; i < 2*N; i++) if (h[i]) used[i]++;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] rand_mask();
    logic [N-1:0] m = '0;
    int kind = int'($urandom % 5);
    case (kind)
      0: m[$urandom % N] = 1'b1;
      1: for (int k = 0; k < N; k++) m[k] = ($urandom % 8) == 0;
      2: for (int k = 0; k < N/4; k++) m[(($urandom % 4) * (N/4)) % N + k] = 1'b1;
      3: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  task automatic set_dir(logic [B-1:0] v, logic [N-1:0] m0, logic [N-1:0] m1,
                         logic [N-1:0] m2, logic [N-1:0] m3);
    vld = v;
    msk = {m3, m2, m1, m0};
    for (int p = 0; p < B; p++) dat[p*DW +: DW] = DW'($urandom);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [B-1:0] er;
    int slot;
    void'($urandom(32'd2024));
    for (int i = 0; i < RING; i++) begin exp_v[i] = '0; exp_d[i] = '0; end

    // R6: leaves quiet under reset
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      checks++;
      if (lv !== '0) begin
        fails++;
        $display("FAIL R6 reset: leaf_valid %h expected %h", lv, {N{1'b0}});
      end
    end
    rst_n = 1'b1;

    for (int n = 0; n < 3000 + D + 4; n++) begin
      if (n > 0) @(negedge clk);
      slot = n % RING;
      checks++;
      if (lv !== exp_v[slot] || ld !== exp_d[slot]) begin
        fails++;
        $display("FAIL R1 R2 cycle %0d: valid %h data %h expected valid %h data %h",
                 n, lv, ld, exp_v[slot], exp_d[slot]);
      end
      exp_v[slot] = '0;
      exp_d[slot] = '0;

      case (n)
        0: set_dir(4'b1111, '1, 16'h0002, 16'h0004, 16'h0008);          // broadcast blocks rest
        1: set_dir(4'b1111, 16'h0001, 16'h0010, 16'h0100, 16'h1000);    // R3 one per quarter
        2: set_dir(4'b1111, 16'h0001, 16'h0002, 16'h0100, 16'h0200);    // R4 quarter conflict
        3: set_dir(4'b0011, 16'h0000, '1, 16'h0000, 16'h0000);          // R5 empty mask
        4: set_dir(4'b1110, '1, 16'h0008, 16'h0080, 16'h0800);          // R4 idle port uses nothing
        5: set_dir(4'b1111, 16'h00FF, 16'hFF00, 16'h0001, 16'h8000);    // halves fill level caps
        6: set_dir(4'b1111, 16'h0001, 16'h0010, 16'h0004, 16'h0100);    // R3 level-1 cap of two
        7, 8, 9: set_dir(4'b1111, 16'h0001 << n, 16'h0010 << (n-7),
                         16'h0100 << (n-7), 16'h1000 << (n-7));         // R7 back to back
        default: begin
          if (n < 3000) begin
            for (int p = 0; p < B; p++) begin
              vld[p] = ($urandom % 4) != 0;
              msk[p*N +: N] = rand_mask();
              dat[p*DW +: DW] = DW'($urandom);
            end
          end else vld = '0;
        end
      endcase

      #1;
      er = model_ready(vld, msk);
      checks++;
      if (rdy !== er) begin
        fails++;
        $display("FAIL R3 R4 cycle %0d: in_ready %b expected %b", n, rdy, er);
      end
      for (int p = 0; p < B; p++)
        if (vld[p] && er[p])
          for (int k = 0; k < N; k++)
            if (msk[p*N+k]) begin
              // R8: a leaf already claimed this cycle would be a double delivery
              exp_v[(n+D) % RING][k] = 1'b1;
              exp_d[(n+D) % RING][k*DW +: DW] = dat[p*DW +: DW];
            end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule